// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Engine

This block is the device-side bit layer of a single-wire, open-drain bus slave. It watches the bus level, which has already been synchronized to the local clock. When the master holds the line low long enough, the block reports a bus reset. It then answers with a presence pulse. Master-initiated time slots are decoded into bits. During a read slot the block pulls the line low when the layer above wants to return a 0.

The byte and command layer above it receives a reset strobe and a bit strobe with the bit's value, and supplies the bit to return in read slots. The master's falling edges are accepted only after a holdoff that follows each return of the line to high. A strobe marks the end of the holdoff that follows each completed slot, so that a self-timed programming interval can be started from that point. All timing is given in microseconds and scaled by the number of clock cycles per microsecond.

Top module: `ow_slave_bit_engine`

## Requirements
- R1: `reset_seen_o` pulses for exactly one cycle, in the cycle after the rising edge that ends a low phase of at least RESET_US. A shorter low phase never produces the pulse.
- R2: After a reset strobe, `bus_pull_o` stays 0 for PRES_WAIT_US, then stays 1 for exactly PRES_LOW_US, then returns to 0.
- R3: A falling edge that arrives while the holdoff after a slot is still running starts no slot and yields no bit.
- R4: A master low phase shorter than SAMPLE_US yields one `bit_valid_o` pulse with `bit_value_o`=1, exactly SAMPLE_US after the falling edge is seen.
- R5: A master low phase longer than SAMPLE_US yields one `bit_valid_o` pulse with `bit_value_o`=0 at the same sample point.
- R6: If `tx_bit_i`=0 when a slot's falling edge is seen, `bus_pull_o` is 1 for exactly SAMPLE_US, starting in the cycle after that edge. The slot then reports `bit_value_o`=0.
- R7: If `tx_bit_i`=1 in a slot, `bus_pull_o` stays 0 for the whole slot.
- R8: Every completed slot is followed by exactly one `holdoff_done_o` pulse. The pulse comes HOLDOFF_US after the later of two points: the sample point and the return of the line to high.
- R9: A reset aborts any slot in progress. No `holdoff_done_o` follows the reset, and the next slot decodes normally.
- R10: During the presence sequence, no bit is decoded and no `holdoff_done_o` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Synchronized bus level (1 = high) |
| tx_bit_i | input | 1 | Bit to return in a read slot |
| bus_pull_o | output | 1 | 1 = pull the bus low |
| reset_seen_o | output | 1 | One-cycle bus reset strobe |
| bit_valid_o | output | 1 | One-cycle decoded bit strobe |
| bit_value_o | output | 1 | Decoded bit, valid with bit_valid_o |
| holdoff_done_o | output | 1 | One-cycle strobe at the end of the post-slot holdoff |

## Verification
The bench builds the block with CYC_PER_US=4 and leaves the microsecond values at their defaults. This gives a 1920-cycle reset threshold, a 120-cycle sample point and an 8-cycle holdoff. At that scale, full reset and presence sequences, long write-0 slots and a falling edge placed inside the holdoff all fit in a short run. Every edge can be checked at its exact cycle.

// File: rtl/ow_bit_pkg.sv
package ow_bit_pkg;

  typedef enum logic [1:0] {
    PR_IDLE  = 2'd0,
    PR_WAIT  = 2'd1,
    PR_DRIVE = 2'd2
  } pres_state_e;

  function automatic int us_to_cyc(input int us, input int cyc_per_us);
    return (us * cyc_per_us < 1) ? 1 : us * cyc_per_us;
  endfunction

endpackage

// File: rtl/ow_reset_presence.sv
module ow_reset_presence
  import ow_bit_pkg::*;
#(
  parameter int RST_CYC = 1920,
  parameter int PDH_CYC = 120,
  parameter int PDL_CYC = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  input  logic rise_i,
  output logic abort_o,
  output logic busy_o,
  output logic pull_o,
  output logic reset_seen_o
);
  localparam int LW = $clog2(RST_CYC + 1);
  localparam int PMAX = (PDH_CYC > PDL_CYC) ? PDH_CYC : PDL_CYC;
  localparam int PW = $clog2(PMAX + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(RST_CYC);
  localparam logic [LW-1:0] LOW_HIT = LW'(RST_CYC - 1);
  localparam logic [PW-1:0] WAIT_END = PW'(PDH_CYC - 1);
  localparam logic [PW-1:0] DRV_END = PW'(PDL_CYC - 1);

  pres_state_e state_q;
  logic [LW-1:0] low_q;
  logic [PW-1:0] ph_q;
  logic pull_q, seen_q;

  // own presence pull is not a master low
  assign abort_o = !bus_i && (state_q != PR_DRIVE) && (low_q == LOW_HIT);
  assign busy_o = (state_q != PR_IDLE);
  assign pull_o = pull_q;
  assign reset_seen_o = seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
    end else if (bus_i || state_q == PR_DRIVE) begin
      low_q <= '0;
    end else if (low_q != LOW_SAT) begin
      low_q <= low_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PR_IDLE;
      ph_q    <= '0;
      pull_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      seen_q <= 1'b0;
      if (rise_i && low_q == LOW_SAT && state_q != PR_DRIVE) begin
        state_q <= PR_WAIT;
        ph_q    <= '0;
        seen_q  <= 1'b1;
      end else begin
        case (state_q)
          PR_WAIT: begin
            if (ph_q == WAIT_END) begin
              state_q <= PR_DRIVE;
              ph_q    <= '0;
              pull_q  <= 1'b1;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
          PR_DRIVE: begin
            if (ph_q == DRV_END) begin
              state_q <= PR_IDLE;
              ph_q    <= '0;
              pull_q  <= 1'b0;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
          default: ph_q <= '0;
        endcase
      end
    end
  end

  AST_SEEN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> !seen_q); // R1
  AST_PRES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PR_DRIVE && ph_q != DRV_END) |=> pull_q); // R2
  AST_NO_PULL_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PR_WAIT) |-> !pull_q); // R2

endmodule

// File: rtl/ow_holdoff_timer.sv
module ow_holdoff_timer #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic start_i,
  input  logic tag_i,
  output logic busy_o,
  output logic done_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] H_END = HW'(HOLD_CYC - 1);

  logic [HW-1:0] cnt_q;
  logic busy_q, tag_q, done_q;

  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      tag_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
        tag_q  <= 1'b0;
      end else if (start_i) begin
        // restart keeps a pending slot mark
        busy_q <= 1'b1;
        cnt_q  <= '0;
        tag_q  <= tag_q | tag_i;
      end else if (busy_q) begin
        if (cnt_q == H_END) begin
          busy_q <= 1'b0;
          tag_q  <= 1'b0;
          done_q <= tag_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q)); // R8

endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
  parameter int SAMPLE_CYC = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic start_i,
  input  logic tx_bit_i,
  input  logic bus_i,
  output logic active_o,
  output logic drive_o,
  output logic end_o,
  output logic bit_valid_o,
  output logic bit_value_o
);
  localparam int CW = $clog2(SAMPLE_CYC + 1);
  localparam logic [CW-1:0] S_END = CW'(SAMPLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic active_q, sampled_q, drive_q, end_q, valid_q, value_q;

  assign active_o = active_q;
  assign drive_o = drive_q;
  assign end_o = end_q;
  assign bit_valid_o = valid_q;
  assign bit_value_o = value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      active_q  <= 1'b0;
      sampled_q <= 1'b0;
      drive_q   <= 1'b0;
      end_q     <= 1'b0;
      valid_q   <= 1'b0;
      value_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      end_q   <= 1'b0;
      if (abort_i) begin
        active_q  <= 1'b0;
        sampled_q <= 1'b0;
        drive_q   <= 1'b0;
      end else if (!active_q) begin
        if (start_i) begin
          active_q  <= 1'b1;
          sampled_q <= 1'b0;
          cnt_q     <= '0;
          drive_q   <= !tx_bit_i;
        end
      end else if (!sampled_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == S_END) begin
          valid_q   <= 1'b1;
          value_q   <= bus_i;
          drive_q   <= 1'b0;
          sampled_q <= 1'b1;
        end
      end else if (bus_i) begin
        active_q <= 1'b0;
        end_q    <= 1'b1;
      end
    end
  end

  AST_DRIVE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_q |-> (active_q && !sampled_q)); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R4

endmodule

// File: rtl/ow_slave_bit_engine.sv
module ow_slave_bit_engine
  import ow_bit_pkg::*;
#(
  parameter int CYC_PER_US   = 100,
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LOW_US  = 120,
  parameter int HOLDOFF_US   = 2,
  parameter int SAMPLE_US    = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  input  logic tx_bit_i,
  output logic bus_pull_o,
  output logic reset_seen_o,
  output logic bit_valid_o,
  output logic bit_value_o,
  output logic holdoff_done_o
);
  localparam int RST_CYC = us_to_cyc(RESET_US, CYC_PER_US);
  localparam int PDH_CYC = us_to_cyc(PRES_WAIT_US, CYC_PER_US);
  localparam int PDL_CYC = us_to_cyc(PRES_LOW_US, CYC_PER_US);
  localparam int HOLD_CYC = us_to_cyc(HOLDOFF_US, CYC_PER_US);
  localparam int SAMPLE_CYC = us_to_cyc(SAMPLE_US, CYC_PER_US);

  logic bus_q, fall, rise;
  logic abort, pres_busy, pres_pull;
  logic slot_active, slot_drive, slot_end, slot_start;
  logic hold_busy, hold_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_q <= 1'b1;
    else         bus_q <= bus_i;
  end

  assign fall = bus_q && !bus_i;
  assign rise = !bus_q && bus_i;
  assign slot_start = fall && !hold_busy && !pres_busy;
  assign hold_start = slot_end || (rise && !slot_active);

  ow_reset_presence #(
    .RST_CYC(RST_CYC),
    .PDH_CYC(PDH_CYC),
    .PDL_CYC(PDL_CYC)
  ) i_pres (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_i       (bus_i),
    .rise_i      (rise),
    .abort_o     (abort),
    .busy_o      (pres_busy),
    .pull_o      (pres_pull),
    .reset_seen_o(reset_seen_o)
  );

  ow_slot_engine #(
    .SAMPLE_CYC(SAMPLE_CYC)
  ) i_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (abort),
    .start_i    (slot_start),
    .tx_bit_i   (tx_bit_i),
    .bus_i      (bus_i),
    .active_o   (slot_active),
    .drive_o    (slot_drive),
    .end_o      (slot_end),
    .bit_valid_o(bit_valid_o),
    .bit_value_o(bit_value_o)
  );

  ow_holdoff_timer #(
    .HOLD_CYC(HOLD_CYC)
  ) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(abort),
    .start_i(hold_start),
    .tag_i  (slot_end),
    .busy_o (hold_busy),
    .done_o (holdoff_done_o)
  );

  assign bus_pull_o = pres_pull || slot_drive;

  AST_HOLDOFF_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_busy && !slot_active) |=> !slot_active); // R3
  AST_RESET_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!slot_active && !hold_busy)); // R9
  AST_PRES_NO_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pres_busy && !slot_active) |=> !slot_active); // R10
  AST_PULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pres_pull && slot_drive)); // R10

endmodule

// File: tb/test_ow_slave_bit_engine.sv
module test_ow_slave_bit_engine;
  localparam int TPU = 4;
  localparam int RST = 480 * TPU;
  localparam int PDH = 30 * TPU;
  localparam int PDL = 120 * TPU;
  localparam int HOLD = 2 * TPU;
  localparam int S = 30 * TPU;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_low = 1'b0;
  logic tx_bit = 1'b1;
  logic bus;
  logic pull, rs, bv, bval, hd;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign bus = !(master_low || pull);

  ow_slave_bit_engine #(.CYC_PER_US(TPU)) i_ow_slave_bit_engine (
    .clk_i(clk), .rst_ni(rst_ni), .bus_i(bus), .tx_bit_i(tx_bit),
    .bus_pull_o(pull), .reset_seen_o(rs), .bit_valid_o(bv),
    .bit_value_o(bval), .holdoff_done_o(hd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // bus reset of given length, then observe presence
  task automatic bus_reset(input int low_len, input bit tx, input bit expect_rst);
    int rs_cnt = 0, rs_idx = -1, p_cnt = 0, p_first = -1, p_last = -1, v_cnt = 0, d_cnt = 0;
    @(negedge clk);
    tx_bit = tx;
    master_low = 1'b1;
    idle(low_len);
    master_low = 1'b0;
    tx_bit = 1'b1;
    for (int i = 1; i <= PDH + PDL + HOLD + 12; i++) begin
      @(negedge clk);
      if (rs) begin rs_cnt++; if (rs_idx < 0) rs_idx = i; end
      if (pull) begin p_cnt++; if (p_first < 0) p_first = i; p_last = i; end
      if (bv) v_cnt++;
      if (hd) d_cnt++;
    end
    if (expect_rst) begin
      chk(rs_cnt == 1 && rs_idx == 1, "R1 reset strobe", rs_idx, 1);
      chk(p_first == PDH + 1, "R2 presence start", p_first, PDH + 1);
      chk(p_last == PDH + PDL && p_cnt == PDL, "R2 presence width", p_cnt, PDL);
      chk(v_cnt == 0, "R10 no bit during presence", v_cnt, 0);
      chk(d_cnt == 0, "R9 no holdoff_done after reset", d_cnt, 0);
    end else begin
      chk(rs_cnt == 0, "R1 short low no reset", rs_cnt, 0);
      chk(p_cnt == 0, "R1 short low no presence", p_cnt, 0);
    end
  endtask

  // one slot; master low for low_len cycles
  task automatic slot(input int low_len, input bit tx, input bit exp_bit, input string req);
    int p_cnt = 0, p_first = -1, p_last = -1, v_cnt = 0, v_idx = -1, v_val = -1;
    int d_cnt = 0, d_idx = -1, exp_d;
    exp_d = (low_len > S) ? low_len + HOLD + 2 : S + HOLD + 3;
    @(negedge clk);
    tx_bit = tx;
    master_low = 1'b1;
    for (int i = 1; i <= exp_d + 10; i++) begin
      @(negedge clk);
      if (pull) begin p_cnt++; if (p_first < 0) p_first = i; p_last = i; end
      if (bv) begin v_cnt++; v_idx = i; v_val = int'(bval); end
      if (hd) begin d_cnt++; d_idx = i; end
      if (i == low_len) master_low = 1'b0;
    end
    tx_bit = 1'b1;
    chk(v_cnt == 1 && v_idx == S + 1, {req, " sample point"}, v_idx, S + 1);
    chk(v_val == int'(exp_bit), {req, " bit value"}, v_val, int'(exp_bit));
    if (!tx) chk(p_cnt == S && p_first == 1 && p_last == S, "R6 read-0 drive window", p_cnt, S);
    else chk(p_cnt == 0, "R7 no drive for tx 1", p_cnt, 0);
    chk(d_cnt == 1 && d_idx == exp_d, "R8 holdoff_done timing", d_idx, exp_d);
  endtask

  // write-1 slot, then a glitch inside the holdoff
  task automatic holdoff_glitch();
    int v_cnt = 0, d_cnt = 0;
    @(negedge clk);
    master_low = 1'b1;
    for (int i = 1; i <= 2 * S + 40; i++) begin
      @(negedge clk);
      if (bv) v_cnt++;
      if (hd) d_cnt++;
      if (i == 24) master_low = 1'b0;
      if (i == S + 4) master_low = 1'b1;
      if (i == S + 6) master_low = 1'b0;
    end
    chk(v_cnt == 1, "R3 fall in holdoff ignored", v_cnt, 1);
    chk(d_cnt == 1, "R3 single holdoff_done", d_cnt, 1);
  endtask

  initial begin
    idle(3);
    chk(pull == 1'b0 && rs == 1'b0, "R1 reset state outputs", int'(pull), 0);
    chk(bv == 1'b0 && hd == 1'b0, "R4 reset state strobes", int'(bv), 0);
    rst_ni = 1'b1;
    idle(HOLD + 4);
    bus_reset(RST + 40, 1'b1, 1'b1);
    slot(24, 1'b1, 1'b1, "R4 write-1");
    slot(280, 1'b1, 1'b0, "R5 write-0");
    slot(8, 1'b0, 1'b0, "R6 read-0");
    slot(8, 1'b1, 1'b1, "R7 read-1");
    slot(4, 1'b1, 1'b1, "R4 short write-1");
    slot(S + 20, 1'b1, 1'b0, "R5 short write-0");
    holdoff_glitch();
    slot(24, 1'b1, 1'b1, "R3 slot after glitch");
    bus_reset(RST - 40, 1'b1, 1'b0);
    idle(HOLD + 4);
    bus_reset(RST, 1'b0, 1'b1);
    slot(280, 1'b1, 1'b0, "R9 write-0 after reset");
    slot(8, 1'b0, 1'b0, "R9 read-0 after reset");
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule